// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers interrupt requests from two source groups into a processor's two interrupt inputs. The first group is a wide bank of level-sensitive peripheral lines (64 by default); the second is a small bank of level-sensitive core-local lines (8 by default). A line counts as pending only while it is both high and enabled. The normal request output goes high when any line in either group is pending. The pending state is never latched, so clearing the cause at the source clears the request.

Software reaches the block over a plain 32-bit word register bus. The bus gives masked pending views of each peripheral word and a summary word. The summary carries the local pending bits, one "something pending" flag per peripheral word, and direct copies of eleven frequently used peripheral lines, so a handler can often dispatch after a single read. Enables are changed only through write-one-to-set and write-one-to-clear registers, so no read-modify-write is ever needed.

A separate fast request path routes the raw, unmasked level of one source to the fast output. The source is chosen by a 7-bit index that spans both groups. The bus has no back-pressure: every cycle with `bus_valid` high is taken as one complete access. A read returns its data on `bus_rdata` one clock later, and `bus_rdata` holds that value until the next read.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all enable masks, the fast enable and the fast index are zero, and `irq_o`, `fiq_o` and `bus_rdata` are low. Reset does not alter the input levels.
- R2: A write to peripheral enable low (0x10) or high (0x14) ORs the written word into mask bits 31:0 or 63:32. A write to local enable (0x18) ORs in only bits 7:0 of the data.
- R3: A write to peripheral disable low (0x1C) or high (0x20) clears every mask bit whose data bit is 1 and leaves the other bits as they were. Local disable (0x24) does the same using only data bits 7:0.
- R4: A read of an enable register returns its mask, zero-extended. A read of a disable register returns the 32-bit inverse of the matching mask; for local disable the upper 24 bits read as 1.
- R5: Reads of 0x04 and 0x08 return (level AND mask) for peripheral lines 31:0 and 63:32. They follow the present input level with no latching.
- R6: The summary word at 0x00 is laid out as follows. Bits 7:0 hold the masked local pending bits. Bit 8 is the OR of masked peripheral pending 31:0, and bit 9 is the OR of 63:32. Bits 10 through 20 are the masked pending bits of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Bits 31:21 are zero.
- R7: `irq_o` is high exactly when some line of either group is both high and enabled.
- R8: Fast control (0x0C) takes the index from data bits 6:0 and the enable from bit 7. A read returns {enable, index} in bits 7:0, with the upper bits zero.
- R9: While the fast enable is set, `fiq_o` follows the raw level of the selected source, regardless of the enable masks. Index 0..63 selects a peripheral line, and 64..71 selects local line (index − 64). While the fast enable is clear, `fiq_o` is low.
- R10: A fast index of 72..127 selects no source, and `fiq_o` stays low.
- R11: A read of an unmapped or misaligned address returns zero. A write to an unmapped or misaligned address, or to 0x00, 0x04 or 0x08, changes no state.
- R12: `bus_rdata` is registered and holds the value from the clock edge that takes the read. `irq_o` and `fiq_o` are registered and change on the first clock edge after the input, mask or control change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq | input | N_PERIPH | Peripheral interrupt levels |
| local_irq | input | N_LOCAL | Core-local interrupt levels |
| bus_valid | input | 1 | Access strobe, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its defaults: 64 peripheral lines, 8 local lines, a 9-bit address and a 32-bit data word. These values make the register map exactly two peripheral words plus one local word. All eleven summary copy bits and both word flags can then be driven. The 7-bit fast index can also be placed at every routing boundary: 63, 64, 71, 72 and 127.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Register identifiers; the numeric value equals the word offset.
  typedef enum logic [3:0] {
    RID_SUMMARY   = 4'd0,
    RID_PEND_LO   = 4'd1,
    RID_PEND_HI   = 4'd2,
    RID_FAST_CTRL = 4'd3,
    RID_EN_LO     = 4'd4,
    RID_EN_HI     = 4'd5,
    RID_EN_LOC    = 4'd6,
    RID_DIS_LO    = 4'd7,
    RID_DIS_HI    = 4'd8,
    RID_DIS_LOC   = 4'd9,
    RID_NONE      = 4'd15
  } reg_id_e;

  localparam int N_REGS   = 10;
  localparam int N_MIRROR = 11;

  // Peripheral lines copied into the summary word, lowest summary bit first.
  function automatic int mirror_line(input int slot);
    case (slot)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      4:       return 19;
      5:       return 53;
      6:       return 54;
      7:       return 55;
      8:       return 56;
      9:       return 57;
      default: return 62;
    endcase
  endfunction

endpackage

// File: rtl/irqagg_mask_regs.sv
module irqagg_mask_regs
  import irqagg_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  reg_id_e             wr_id,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [N_PERIPH-1:0] per_en,
  output logic [N_LOCAL-1:0]  loc_en,
  output logic                fast_en,
  output logic [IDX_W-1:0]    fast_idx
);

  localparam int PERIPH_WORDS = N_PERIPH / DATA_W;

  // One mask word per peripheral register pair.
  for (genvar w = 0; w < PERIPH_WORDS; w++) begin : g_word
    localparam reg_id_e SET_ID = reg_id_e'(4'(int'(RID_EN_LO) + w));
    localparam reg_id_e CLR_ID = reg_id_e'(4'(int'(RID_DIS_LO) + w));
    logic [DATA_W-1:0] en_word;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_word <= '0;
      end else if (wr_stb && wr_id == SET_ID) begin
        en_word <= en_word | wr_data;
      end else if (wr_stb && wr_id == CLR_ID) begin
        en_word <= en_word & ~wr_data;
      end
    end

    assign per_en[w*DATA_W +: DATA_W] = en_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_en <= '0;
    end else if (wr_stb && wr_id == RID_EN_LOC) begin
      loc_en <= loc_en | wr_data[N_LOCAL-1:0];
    end else if (wr_stb && wr_id == RID_DIS_LOC) begin
      loc_en <= loc_en & ~wr_data[N_LOCAL-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_idx <= '0;
      fast_en  <= 1'b0;
    end else if (wr_stb && wr_id == RID_FAST_CTRL) begin
      fast_idx <= wr_data[IDX_W-1:0];
      fast_en  <= wr_data[IDX_W];
    end
  end

  AST_EN_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_id == RID_EN_LO || wr_id == RID_EN_HI || wr_id == RID_EN_LOC))
      |=> (((per_en & $past(per_en)) == $past(per_en)) && ((loc_en & $past(loc_en)) == $past(loc_en)))); // R2

  AST_DIS_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_id == RID_DIS_LO || wr_id == RID_DIS_HI || wr_id == RID_DIS_LOC))
      |=> (((per_en & ~$past(per_en)) == '0) && ((loc_en & ~$past(loc_en)) == '0))); // R3

  AST_NO_STATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_id == RID_NONE || wr_id == RID_SUMMARY || wr_id == RID_PEND_LO || wr_id == RID_PEND_HI))
      |=> ($stable(per_en) && $stable(loc_en) && $stable(fast_en) && $stable(fast_idx))); // R11

endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending
  import irqagg_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8,
  parameter int DATA_W   = 32
) (
  input  logic [N_PERIPH-1:0] per_lvl,
  input  logic [N_LOCAL-1:0]  loc_lvl,
  input  logic [N_PERIPH-1:0] per_en,
  input  logic [N_LOCAL-1:0]  loc_en,
  output logic [N_PERIPH-1:0] per_pend,
  output logic [DATA_W-1:0]   summary,
  output logic                any_pend
);

  localparam int PERIPH_WORDS = N_PERIPH / DATA_W;
  localparam int FLAG_BASE    = N_LOCAL;
  localparam int MIRROR_BASE  = N_LOCAL + PERIPH_WORDS;
  localparam int USED_BITS    = MIRROR_BASE + N_MIRROR;

  logic [N_LOCAL-1:0] loc_pend;

  assign per_pend = per_lvl & per_en;
  assign loc_pend = loc_lvl & loc_en;

  assign summary[N_LOCAL-1:0] = loc_pend;

  for (genvar w = 0; w < PERIPH_WORDS; w++) begin : g_flag
    assign summary[FLAG_BASE + w] = |per_pend[w*DATA_W +: DATA_W];
  end

  for (genvar m = 0; m < N_MIRROR; m++) begin : g_mirror
    localparam int LINE = mirror_line(m);
    assign summary[MIRROR_BASE + m] = per_pend[LINE];
  end

  assign summary[DATA_W-1:USED_BITS] = '0;

  assign any_pend = (|per_pend) | (|loc_pend);

endmodule

// File: rtl/irqagg_fast_route.sv
module irqagg_fast_route #(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8,
  parameter int IDX_W    = 7
) (
  input  logic [N_PERIPH-1:0] per_lvl,
  input  logic [N_LOCAL-1:0]  loc_lvl,
  input  logic                fast_en,
  input  logic [IDX_W-1:0]    fast_idx,
  output logic                fiq_next
);

  localparam int PER_SEL_W = $clog2(N_PERIPH);
  localparam int LOC_SEL_W = $clog2(N_LOCAL);

  logic [LOC_SEL_W-1:0] loc_sel;
  logic                 picked;

  assign loc_sel = LOC_SEL_W'(fast_idx - IDX_W'(N_PERIPH));

  always_comb begin
    picked = 1'b0;
    if (fast_idx < IDX_W'(N_PERIPH)) begin
      picked = per_lvl[fast_idx[PER_SEL_W-1:0]];
    end else if (fast_idx < IDX_W'(N_PERIPH + N_LOCAL)) begin
      picked = loc_lvl[loc_sel];
    end
  end

  assign fiq_next = fast_en & picked;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int N_PERIPH = 64,
  parameter int N_LOCAL  = 8,
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] periph_irq,
  input  logic [N_LOCAL-1:0]  local_irq,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                fiq_o
);

  localparam int WIDX_W   = ADDR_W - 2;
  localparam int N_SOURCE = N_PERIPH + N_LOCAL;

  logic [WIDX_W-1:0]   word_idx;
  reg_id_e             acc_id;
  logic [N_PERIPH-1:0] per_en;
  logic [N_LOCAL-1:0]  loc_en;
  logic                fast_en;
  logic [IDX_W-1:0]    fast_idx;
  logic [N_PERIPH-1:0] per_pend;
  logic [DATA_W-1:0]   summary;
  logic                any_pend;
  logic                fiq_next;
  logic [DATA_W-1:0]   rd_word;

  // Address decode: aligned words inside the map, everything else unmapped.
  assign word_idx = bus_addr[ADDR_W-1:2];
  always_comb begin
    if (bus_addr[1:0] == 2'b00 && word_idx < WIDX_W'(N_REGS)) begin
      acc_id = reg_id_e'(word_idx[3:0]);
    end else begin
      acc_id = RID_NONE;
    end
  end

  irqagg_mask_regs #(
    .N_PERIPH (N_PERIPH),
    .N_LOCAL  (N_LOCAL),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (bus_valid & bus_write),
    .wr_id    (acc_id),
    .wr_data  (bus_wdata),
    .per_en   (per_en),
    .loc_en   (loc_en),
    .fast_en  (fast_en),
    .fast_idx (fast_idx)
  );

  irqagg_pending #(
    .N_PERIPH (N_PERIPH),
    .N_LOCAL  (N_LOCAL),
    .DATA_W   (DATA_W)
  ) u_pend (
    .per_lvl  (periph_irq),
    .loc_lvl  (local_irq),
    .per_en   (per_en),
    .loc_en   (loc_en),
    .per_pend (per_pend),
    .summary  (summary),
    .any_pend (any_pend)
  );

  irqagg_fast_route #(
    .N_PERIPH (N_PERIPH),
    .N_LOCAL  (N_LOCAL),
    .IDX_W    (IDX_W)
  ) u_fast (
    .per_lvl  (periph_irq),
    .loc_lvl  (local_irq),
    .fast_en  (fast_en),
    .fast_idx (fast_idx),
    .fiq_next (fiq_next)
  );

  // Read selection.
  always_comb begin
    case (acc_id)
      RID_SUMMARY:   rd_word = summary;
      RID_PEND_LO:   rd_word = per_pend[0 +: DATA_W];
      RID_PEND_HI:   rd_word = per_pend[DATA_W +: DATA_W];
      RID_FAST_CTRL: rd_word = DATA_W'({fast_en, fast_idx});
      RID_EN_LO:     rd_word = per_en[0 +: DATA_W];
      RID_EN_HI:     rd_word = per_en[DATA_W +: DATA_W];
      RID_EN_LOC:    rd_word = DATA_W'(loc_en);
      RID_DIS_LO:    rd_word = ~per_en[0 +: DATA_W];
      RID_DIS_HI:    rd_word = ~per_en[DATA_W +: DATA_W];
      RID_DIS_LOC:   rd_word = ~DATA_W'(loc_en);
      default:       rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_valid && !bus_write) begin
      bus_rdata <= rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= any_pend;
      fiq_o <= fiq_next;
    end
  end

  AST_FIQ_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> !fiq_o); // R9

  AST_FIQ_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_idx >= IDX_W'(N_SOURCE)) |=> !fiq_o); // R10

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en == '0 && loc_en == '0) |=> !irq_o); // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && acc_id == RID_NONE) |=> (bus_rdata == '0)); // R11

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> $stable(bus_rdata)); // R12

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] periph_irq = '0;
  logic [7:0]  local_irq = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        fiq_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  irq_aggregator u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_irq (periph_irq),
    .local_irq  (local_irq),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clear_all();
    wr(9'h1C, 32'hFFFF_FFFF);
    wr(9'h20, 32'hFFFF_FFFF);
    wr(9'h24, 32'hFFFF_FFFF);
    wr(9'h0C, 32'h0);
  endtask

  task automatic t_reset();
    step();
    chk("R1 irq_o after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 fiq_o after reset", {31'b0, fiq_o}, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd(9'h10, rv); chk("R1 enable low", rv, 32'h0);
    rd(9'h14, rv); chk("R1 enable high", rv, 32'h0);
    rd(9'h18, rv); chk("R1 local enable", rv, 32'h0);
    rd(9'h0C, rv); chk("R1 fast control", rv, 32'h0);
    rd(9'h1C, rv); chk("R4 disable low inverse at reset", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable();
    wr(9'h10, 32'h0000_00F0);
    wr(9'h10, 32'h0F00_0000);
    rd(9'h10, rv); chk("R2 enable low accumulates", rv, 32'h0F00_00F0);
    wr(9'h14, 32'h8000_0001);
    rd(9'h14, rv); chk("R2 enable high", rv, 32'h8000_0001);
    wr(9'h18, 32'hFFFF_FF3C);
    rd(9'h18, rv); chk("R2 local enable low byte only", rv, 32'h0000_003C);
    rd(9'h24, rv); chk("R4 local disable inverse", rv, 32'hFFFF_FFC3);
    rd(9'h20, rv); chk("R4 disable high inverse", rv, 32'h7FFF_FFFE);
    rd(9'h1C, rv); chk("R4 disable low inverse", rv, 32'hF0FF_FF0F);
  endtask

  task automatic t_disable();
    wr(9'h1C, 32'h0000_0030);
    rd(9'h10, rv); chk("R3 disable low clears ones", rv, 32'h0F00_00C0);
    wr(9'h20, 32'h0000_0001);
    rd(9'h14, rv); chk("R3 disable high", rv, 32'h8000_0000);
    wr(9'h24, 32'hFFFF_FF04);
    rd(9'h18, rv); chk("R3 local disable", rv, 32'h0000_0038);
    wr(9'h1C, 32'h0);
    rd(9'h10, rv); chk("R3 zero disable keeps mask", rv, 32'h0F00_00C0);
  endtask

  task automatic t_pending();
    clear_all();
    wr(9'h10, 32'hFFFF_0000);
    wr(9'h14, 32'h0000_FFFF);
    periph_irq = 64'h1234_5678_9ABC_DEF0;
    step();
    rd(9'h04, rv); chk("R5 pending low", rv, 32'h9ABC_0000);
    rd(9'h08, rv); chk("R5 pending high", rv, 32'h0000_5678);
    periph_irq = '0;
    step();
    rd(9'h04, rv); chk("R5 pending follows level", rv, 32'h0);
  endtask

  task automatic sum_case(input string tag, input logic [63:0] p, input logic [7:0] l,
                          input logic [31:0] exp);
    periph_irq = p; local_irq = l;
    step();
    rd(9'h00, rv); chk(tag, rv, exp);
  endtask

  task automatic t_summary();
    clear_all();
    wr(9'h10, 32'hFFFF_FFFF);
    wr(9'h14, 32'hFFFF_FFFF);
    wr(9'h18, 32'hFFFF_FFFF);
    sum_case("R6 low mirrors", 64'h0000_0000_000C_0680, 8'h81, 32'h0000_7D81);
    sum_case("R6 high mirrors", 64'h43E0_0000_0000_0000, 8'h00, 32'h001F_8200);
    sum_case("R6 low word flag only", 64'h0000_0000_0000_0001, 8'h00, 32'h0000_0100);
    sum_case("R6 high word flag only", 64'h0000_0100_0000_0000, 8'h00, 32'h0000_0200);
    sum_case("R6 local bits", 64'h0, 8'h02, 32'h0000_0002);
    wr(9'h20, 32'h4000_0000);
    sum_case("R6 masked line hidden", 64'h4000_0000_0000_0000, 8'h00, 32'h0);
    periph_irq = '0; local_irq = '0;
  endtask

  task automatic t_irq();
    clear_all();
    periph_irq = '1; local_irq = '1;
    step();
    chk("R7 no enables no irq", {31'b0, irq_o}, 32'h0);
    periph_irq = '0; local_irq = '0;
    wr(9'h18, 32'h08);
    wr(9'h14, 32'h0000_2000);
    step();
    chk("R7 enabled but low", {31'b0, irq_o}, 32'h0);
    local_irq = 8'h08;
    step();
    chk("R7 local line raises irq", {31'b0, irq_o}, 32'h1);
    local_irq = '0;
    step();
    chk("R7 local line drops irq", {31'b0, irq_o}, 32'h0);
    periph_irq = 64'h0000_2000_0000_0000;
    step();
    chk("R7 peripheral line raises irq", {31'b0, irq_o}, 32'h1);
    wr(9'h20, 32'h0000_2000);
    chk("R12 irq_o still old right after mask edge", {31'b0, irq_o}, 32'h1);
    step();
    chk("R12 irq_o follows mask one clock later", {31'b0, irq_o}, 32'h0);
    periph_irq = '0;
  endtask

  task automatic t_fast_ctrl();
    wr(9'h0C, 32'hFFFF_FF85);
    rd(9'h0C, rv); chk("R8 fast control readback", rv, 32'h0000_0085);
    wr(9'h0C, 32'h0000_003F);
    rd(9'h0C, rv); chk("R8 fast control disabled", rv, 32'h0000_003F);
  endtask

  task automatic t_fast_route();
    clear_all();
    periph_irq = 64'h20; local_irq = '0;
    wr(9'h0C, 32'h85);
    step();
    chk("R9 unmasked peripheral source", {31'b0, fiq_o}, 32'h1);
    periph_irq = '0;
    step();
    chk("R9 follows raw level low", {31'b0, fiq_o}, 32'h0);
    wr(9'h0C, 32'hBF);
    periph_irq = 64'h8000_0000_0000_0000;
    step();
    chk("R9 index 63", {31'b0, fiq_o}, 32'h1);
    wr(9'h0C, 32'h3F);
    step();
    chk("R9 enable clear forces low", {31'b0, fiq_o}, 32'h0);
    periph_irq = '0;
    wr(9'h0C, 32'hC6);
    local_irq = 8'h40;
    step();
    chk("R9 index 70 local 6", {31'b0, fiq_o}, 32'h1);
    local_irq = 8'hBF;
    step();
    chk("R9 other local lines ignored", {31'b0, fiq_o}, 32'h0);
    wr(9'h0C, 32'hC0);
    local_irq = 8'h01;
    step();
    chk("R9 index 64 local 0", {31'b0, fiq_o}, 32'h1);
    local_irq = '0;
  endtask

  task automatic t_fast_range();
    periph_irq = '1; local_irq = '1;
    wr(9'h0C, 32'hC7);
    step();
    chk("R10 index 71 still valid", {31'b0, fiq_o}, 32'h1);
    wr(9'h0C, 32'hC8);
    step();
    chk("R10 index 72 no source", {31'b0, fiq_o}, 32'h0);
    wr(9'h0C, 32'hFF);
    step();
    chk("R10 index 127 no source", {31'b0, fiq_o}, 32'h0);
    periph_irq = '0; local_irq = '0;
  endtask

  task automatic t_unmapped();
    clear_all();
    wr(9'h10, 32'h0000_0011);
    wr(9'h18, 32'h0000_0005);
    wr(9'h0C, 32'h0000_008A);
    rd(9'h028, rv); chk("R11 read past map", rv, 32'h0);
    rd(9'h1FC, rv); chk("R11 read top of window", rv, 32'h0);
    rd(9'h012, rv); chk("R11 misaligned read", rv, 32'h0);
    wr(9'h028, 32'hFFFF_FFFF);
    wr(9'h000, 32'hFFFF_FFFF);
    wr(9'h004, 32'hFFFF_FFFF);
    wr(9'h008, 32'hFFFF_FFFF);
    wr(9'h011, 32'hFFFF_FFFF);
    rd(9'h10, rv); chk("R11 enable low untouched", rv, 32'h0000_0011);
    rd(9'h14, rv); chk("R11 enable high untouched", rv, 32'h0);
    rd(9'h18, rv); chk("R11 local enable untouched", rv, 32'h0000_0005);
    rd(9'h0C, rv); chk("R11 fast control untouched", rv, 32'h0000_008A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_disable();
    t_pending();
    t_summary();
    t_irq();
    t_fast_ctrl();
    t_fast_route();
    t_fast_range();
    t_unmapped();
    step();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule